// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns one 6-bit operand specifier into an effective operand for a 16-bit processor with eight general registers and two-address instructions. The upper three bits of the specifier choose one of eight addressing modes and the lower three bits name a register. The odd modes are the deferred (indirect) forms of the even mode below them. The block reads and updates the register file through one read port and one write port. It fetches words from memory over a request/acknowledge handshake. Those words are index words taken from the instruction stream and pointers for the deferred modes.

A decoder pulses `start_i` with the specifier and a byte/word flag. The sequencer walks the mode's steps: it reads the register, steps it up or down, reads the index word at the program counter and advances the counter, and follows a pointer. It then pulses `done_o`. At that point `is_reg_o` says whether the operand is the named register itself. When it is not, `addr_o` holds the operand's memory address. Register 7 is the program counter and register 6 is the stack pointer. Used with register 7, the post-increment mode gives an immediate operand, its deferred form gives an absolute address, and the index modes give PC-relative addresses.

Top module: `amode_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are low.
- R2: Mode 0 (`spec_i[5:3]`=0) reports `is_reg_o`=1 with `reg_o`=`spec_i[2:0]`. It makes no memory access and no register write.
- R3: Mode 1 reports `is_reg_o`=0 and `addr_o` equal to the register contents, and leaves the register unchanged.
- R4: Mode 2 reports the old register value as the address, then adds the step to the register. The step is 1 when `byte_i`=1 and 2 when `byte_i`=0.
- R5: Mode 4 first subtracts the step from the register, then reports the new value as the address.
- R6: Mode 3 (post-increment deferred) and mode 5 (pre-decrement deferred) always step the register by 2. The operand address is then the word read from memory at the old value (mode 3) or at the new value (mode 5).
- R7: With register 6 or 7, modes 2 and 4 always step by 2, even when `byte_i`=1.
- R8: Modes 6 and 7 read an index word X from memory at the program counter (register 7) and add 2 to the counter. The sum is the named register plus X; when the register is 7, its value after the advance is used. Mode 6 reports the sum. Mode 7 reads the operand address from memory at the sum.
- R9: `done_o` is high for exactly one cycle. `is_reg_o`, `reg_o` and `addr_o` hold until the next accepted start. A start while `busy_o` is high is ignored.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i`. Each mode makes exactly the memory reads it needs: none for modes 0, 1, 2 and 4, one for modes 3, 5 and 6, and two for mode 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving `spec_i` |
| spec_i | input | 6 | Specifier: [5:3] mode, [2:0] register |
| byte_i | input | 1 | 1 = byte operand, 0 = word operand |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| is_reg_o | output | 1 | Operand is the register itself |
| reg_o | output | 3 | Register number of the specifier |
| addr_o | output | 16 | Operand address when `is_reg_o` is 0 |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 16 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 16 | Register file write data |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge, data valid |
| mem_rdata_i | input | 16 | Memory read data |

## Verification
The bench runs every mode on an ordinary register in word form. It repeats the stepping modes in byte form, so that a step of 1 is told apart from a step of 2, and pre-decrement is told apart from post-increment by which value comes back as the address. The same modes are run on registers 6 and 7, where byte form must still step by 2. Those runs also show the immediate, absolute and PC-relative cases and separate the index base taken from a general register from the one taken from the already-advanced counter. For each run the bench counts memory transfers and register writes, which tells direct, deferred and index forms apart. Directed runs cover the reset state, a start pulsed while busy, and outputs that must hold after completion.

// File: rtl/amode_pkg.sv
package amode_pkg;
  typedef enum logic [2:0] {
    M_REG     = 3'd0,
    M_REG_DEF = 3'd1,
    M_INC     = 3'd2,
    M_INC_DEF = 3'd3,
    M_DEC     = 3'd4,
    M_DEC_DEF = 3'd5,
    M_IDX     = 3'd6,
    M_IDX_DEF = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RREG,
    S_RPC,
    S_FETCHX,
    S_FETCHP,
    S_DONE
  } state_e;
endpackage

// File: rtl/amode_calc.sv
// Register stepping and address for modes 1..5.
module amode_calc
  import amode_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6
) (
  input  mode_e         mode_i,
  input  logic [RW-1:0] rn_i,
  input  logic          byte_i,
  input  logic [DW-1:0] rval_i,
  output logic          we_o,
  output logic [DW-1:0] wval_o,
  output logic [DW-1:0] ea_o
);
  logic          full_step;
  logic [DW-1:0] step;
  logic [DW-1:0] inc_val;
  logic [DW-1:0] dec_val;

  // deferred forms and SP/PC always move a whole word
  assign full_step = mode_i[0] | (rn_i >= RW'(SP_IDX)) | ~byte_i;
  assign step      = full_step ? DW'(2) : DW'(1);
  assign inc_val   = rval_i + step;
  assign dec_val   = rval_i - step;

  always_comb begin
    we_o   = 1'b0;
    wval_o = rval_i;
    ea_o   = rval_i;
    unique case (mode_i)
      M_INC, M_INC_DEF: begin
        we_o   = 1'b1;
        wval_o = inc_val;
      end
      M_DEC, M_DEC_DEF: begin
        we_o   = 1'b1;
        wval_o = dec_val;
        ea_o   = dec_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/amode_index.sv
// Index sum; the PC is advanced past X before it serves as base.
module amode_index #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] base_i,
  input  logic          base_is_pc_i,
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] pc_next_o,
  output logic [DW-1:0] ea_o
);
  assign pc_next_o = pc_i + DW'(2);
  assign ea_o      = (base_is_pc_i ? pc_next_o : base_i) + x_i;
endmodule

// File: rtl/amode_seq.sv
module amode_seq
  import amode_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW+2:0] spec_i,
  input  logic          byte_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          is_reg_o,
  output logic [RW-1:0] reg_o,
  output logic [DW-1:0] addr_o,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam logic [RW-1:0] PC_R = RW'(PC_IDX);

  state_e        state_q;
  mode_e         mode_q;
  logic [RW-1:0] rn_q;
  logic          byte_q;
  logic [DW-1:0] rval_q;
  logic [DW-1:0] pc_q;
  logic [DW-1:0] ptr_q;
  logic [DW-1:0] ea_q;
  logic          is_reg_q;

  logic          calc_we;
  logic [DW-1:0] calc_wval;
  logic [DW-1:0] calc_ea;
  logic [DW-1:0] idx_pc_next;
  logic [DW-1:0] idx_ea;

  amode_calc #(.DW(DW), .RW(RW), .SP_IDX(SP_IDX)) i_calc (
    .mode_i (mode_q),
    .rn_i   (rn_q),
    .byte_i (byte_q),
    .rval_i (rf_rdata_i),
    .we_o   (calc_we),
    .wval_o (calc_wval),
    .ea_o   (calc_ea)
  );

  amode_index #(.DW(DW)) i_index (
    .pc_i         (pc_q),
    .base_i       (rval_q),
    .base_is_pc_i (rn_q == PC_R),
    .x_i          (mem_rdata_i),
    .pc_next_o    (idx_pc_next),
    .ea_o         (idx_ea)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q   <= M_REG;
      rn_q     <= '0;
      byte_q   <= 1'b0;
      rval_q   <= '0;
      pc_q     <= '0;
      ptr_q    <= '0;
      ea_q     <= '0;
      is_reg_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_q  <= mode_e'(spec_i[RW+2:RW]);
          rn_q    <= spec_i[RW-1:0];
          byte_q  <= byte_i;
          state_q <= S_RREG;
        end
        S_RREG: begin
          rval_q   <= rf_rdata_i;
          is_reg_q <= (mode_q == M_REG);
          unique case (mode_q)
            M_REG: state_q <= S_DONE;
            M_REG_DEF, M_INC, M_DEC: begin
              ea_q    <= calc_ea;
              state_q <= S_DONE;
            end
            M_INC_DEF, M_DEC_DEF: begin
              ptr_q   <= calc_ea;
              state_q <= S_FETCHP;
            end
            default: state_q <= S_RPC;
          endcase
        end
        S_RPC: begin
          pc_q    <= rf_rdata_i;
          state_q <= S_FETCHX;
        end
        S_FETCHX: if (mem_ack_i) begin
          if (mode_q == M_IDX_DEF) begin
            ptr_q   <= idx_ea;
            state_q <= S_FETCHP;
          end else begin
            ea_q    <= idx_ea;
            state_q <= S_DONE;
          end
        end
        S_FETCHP: if (mem_ack_i) begin
          ea_q    <= mem_rdata_i;
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_we_o    = 1'b0;
    rf_waddr_o = rn_q;
    rf_wdata_o = calc_wval;
    if (state_q == S_RREG) begin
      rf_we_o = calc_we;
    end else if (state_q == S_FETCHX && mem_ack_i) begin
      rf_we_o    = 1'b1;
      rf_waddr_o = PC_R;
      rf_wdata_o = idx_pc_next;
    end
  end

  assign rf_raddr_o = (state_q == S_RPC) ? PC_R : rn_q;
  assign mem_req_o  = (state_q == S_FETCHX) || (state_q == S_FETCHP);
  assign mem_addr_o = (state_q == S_FETCHX) ? pc_q : ptr_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign is_reg_o   = is_reg_q;
  assign reg_o      = rn_q;
  assign addr_o     = ea_q;
endmodule

// File: rtl/amode_seq_chk.sv
module amode_seq_chk #(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          is_reg_o,
  input logic [DW-1:0] addr_o,
  input logic          rf_we_o,
  input logic [RW-1:0] rf_waddr_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_ack_i
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rf_we_o && !done_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(addr_o) && $stable(is_reg_o)));

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  pc_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && rf_we_o) |-> (rf_waddr_o == RW'(7)));
endmodule

bind amode_seq amode_seq_chk #(.DW(DW), .RW(RW)) i_amode_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .is_reg_o   (is_reg_o),
  .addr_o     (addr_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/test_amode_seq.sv
module test_amode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic        byte_m = 1'b0;
  logic        busy, done, is_reg;
  logic [2:0]  reg_n;
  logic [15:0] addr;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr, mem_rdata;

  logic [15:0] rf [8];
  logic        rf_load = 1'b0;
  int          n_mem, n_wr;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  amode_seq i_amode_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .spec_i(spec), .byte_i(byte_m),
    .busy_o(busy), .done_o(done), .is_reg_o(is_reg), .reg_o(reg_n), .addr_o(addr),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [15:0] init_val(int k);
    return 16'h2000 + 16'(k) * 16'h0102;
  endfunction

  function automatic logic [15:0] mem_fn(logic [15:0] a);
    return a + 16'h0100;
  endfunction

  // register file and memory models
  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem_fn(mem_addr);

  always_ff @(posedge clk) begin
    if (rf_load) begin
      for (int k = 0; k < 8; k++) rf[k] <= init_val(k);
      n_mem <= 0;
      n_wr  <= 0;
    end else begin
      if (rf_we) begin
        rf[rf_waddr] <= rf_wdata;
        n_wr <= n_wr + 1;
      end
      if (mem_req && mem_ack) n_mem <= n_mem + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req && !mem_ack;
  end

  // {byte, mode, reg}
  localparam logic [6:0] VEC [19] = '{
    7'o002, 7'o007, 7'o012, 7'o022, 7'o122, 7'o126, 7'o027, 7'o032, 7'o131,
    7'o042, 7'o143, 7'o147, 7'o054, 7'o155, 7'o062, 7'o067, 7'o066, 7'o072,
    7'o177
  };

  function automatic void model(input logic [6:0] v, output logic ir,
                                output logic [15:0] ea, output logic [15:0] rn_a,
                                output logic [15:0] pc_a, output int nm, output int nw);
    logic [15:0] r [8];
    logic [15:0] st, x, p;
    int n, m;
    for (int k = 0; k < 8; k++) r[k] = init_val(k);
    n  = int'(v[2:0]);
    m  = int'(v[5:3]);
    st = (v[6] && n < 6) ? 16'd1 : 16'd2;
    ir = 1'b0; ea = '0; nm = 0; nw = 0;
    case (m)
      0: ir = 1'b1;
      1: ea = r[n];
      2: begin ea = r[n]; r[n] = r[n] + st; nw = 1; end
      3: begin ea = mem_fn(r[n]); r[n] = r[n] + 16'd2; nm = 1; nw = 1; end
      4: begin r[n] = r[n] - st; ea = r[n]; nw = 1; end
      5: begin r[n] = r[n] - 16'd2; ea = mem_fn(r[n]); nm = 1; nw = 1; end
      default: begin
        x    = mem_fn(r[7]);
        r[7] = r[7] + 16'd2;
        p    = r[n] + x;
        nm   = 1; nw = 1;
        if (m == 7) begin ea = mem_fn(p); nm = 2; end
        else ea = p;
      end
    endcase
    rn_a = r[n];
    pc_a = r[7];
  endfunction

  function automatic string tag_of(logic [6:0] v);
    case (v[5:3])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return (v[6] && v[2:0] >= 3'd6) ? "R7" : "R4";
      3'd4: return (v[6] && v[2:0] >= 3'd6) ? "R7" : "R5";
      3'd3, 3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string rq, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic load_regs();
    @(negedge clk) rf_load = 1'b1;
    @(negedge clk) rf_load = 1'b0;
  endtask

  task automatic pulse_start(logic [6:0] v);
    spec   = v[5:0];
    byte_m = v[6];
    start  = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int t = 0;
    ok = 1'b1;
    while (!done && t < 50) begin
      @(negedge clk);
      t++;
    end
    if (!done) ok = 1'b0;
  endtask

  task automatic check_result(logic [6:0] v, string rq);
    logic ir; logic [15:0] ea, rn_a, pc_a; int nm, nw;
    model(v, ir, ea, rn_a, pc_a, nm, nw);
    chk(rq, "is_reg", 16'(is_reg), 16'(ir));
    chk(rq, "reg", 16'(reg_n), 16'(v[2:0]));
    if (!ir) chk(rq, "addr", addr, ea);
    chk(rq, "reg value", rf[v[2:0]], rn_a);
    chk(rq, "pc value", rf[7], pc_a);
    chk("R10", "mem reads", 16'(n_mem), 16'(nm));
    chk(rq, "reg writes", 16'(n_wr), 16'(nw));
  endtask

  initial begin
    bit ok;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 16'(busy), 16'd0);
    chk("R1", "done", 16'(done), 16'd0);
    chk("R1", "mem_req", 16'(mem_req), 16'd0);
    chk("R1", "rf_we", 16'(rf_we), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      load_regs();
      pulse_start(VEC[i]);
      wait_done(ok);
      chk("R9", "done seen", 16'(ok), 16'd1);
      check_result(VEC[i], tag_of(VEC[i]));
      @(negedge clk);
      chk("R9", "done width", 16'(done), 16'd0);
      chk("R1", "idle after", 16'(busy), 16'd0);
    end

    // R9: start while busy is ignored
    load_regs();
    pulse_start(7'o077);
    @(negedge clk);
    pulse_start(7'o000);
    wait_done(ok);
    chk("R9", "done seen", 16'(ok), 16'd1);
    check_result(7'o077, "R9");
    @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk("R9", "no restart", 16'(busy), 16'd0);
    end

    // R9: outputs hold while idle
    held = addr;
    repeat (5) @(negedge clk);
    chk("R9", "addr held", addr, held);
    chk("R9", "reg held", 16'(reg_n), 16'd7);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule